// File: doc/BRIEF.md
# Event-Driven Down Counter with Arm Control

This block counts down on single-cycle strobes from one of four event lines, chosen by a field in an 8-bit control register. Counting only happens while the control register's enable flag is set. Software can set that flag directly. Alternatively, software can pick one of four external trigger lines, and a strobe on the chosen line sets the flag. In that case a software attempt to set the flag is ignored.

When a counted event arrives while the count is zero, the block reloads the count from a reload register and emits a one-cycle underflow pulse. In single-shot mode the underflow also drops the enable flag. In continuous mode counting carries on from the reloaded value.

Software reaches the block through a write port and a registered read port with two addresses:
- Address 0 is the control register.
- Address 1 is the count. A write to address 1 loads both the count and the reload value. A read from address 1 returns the live count.

Top module: `evt_down_counter`

## Requirements
- R1: After reset the control register reads 0x00, the count reads 0 and `uf_pulse` is low.
- R2: A control write stores bits 0–5 and 7. Bit 6 always reads 0. `rd_data` shows the register chosen by `rd_sel` (0 = control, 1 = count) one clock after `rd_sel` is applied, zero-extended.
- R3: When a control write has bit 3 = 0, bit 0 of the written value sets the enable flag (1) or clears it (0).
- R4: When a control write has bit 3 = 1, a 1 in bit 0 leaves the enable flag unchanged. A 0 in bit 0 still clears it.
- R5: Control bits 3:1 pick the arm source: 100 = `arm_ev0`, 101 = `arm_ev1`, 110 = `arm_nbr_uf`, 111 = `arm_cap`, and 0xx = none. A strobe on the selected source sets the enable flag on the next clock. Strobes on other sources have no effect.
- R6: Control bits 5:4 pick the count event: 00 = `cnt_ev_in`, 01 = `cnt_ev_cap`, 10 = `cnt_ev_xfer`, 11 = `cnt_ev_xfer_uf`. Each strobe of the selected event lowers the count by exactly one while enabled. Unselected events, and any event while disabled, leave the count unchanged.
- R7: A write with `wr_sel` = 1 loads both the count and the reload value. If a count event arrives in the same cycle, the write wins and the event is dropped.
- R8: A counted event at count 0 reloads the count from the reload value. `uf_pulse` is high for exactly the following cycle.
- R9: Control bit 7 sets the mode. In single-shot mode (0) an underflow clears the enable flag. In continuous mode (1) the enable flag stays set.
- R10: If a single-shot underflow and a software write of 1 to the enable flag happen in the same cycle, the flag ends at 0. A selected arm strobe in that same cycle leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 count/reload |
| wr_data | input | CNT_W | Write data (control uses bits 7:0) |
| rd_sel | input | 1 | Read target: 0 control, 1 count |
| rd_data | output | CNT_W | Registered read data |
| arm_ev0 | input | 1 | Arm source, code 100 |
| arm_ev1 | input | 1 | Arm source, code 101 |
| arm_nbr_uf | input | 1 | Arm source, code 110 (neighbour underflow) |
| arm_cap | input | 1 | Arm source, code 111 (capture-enable strobe) |
| cnt_ev_in | input | 1 | Count event, code 00 |
| cnt_ev_cap | input | 1 | Count event, code 01 (capture) |
| cnt_ev_xfer | input | 1 | Count event, code 10 (one transfer done) |
| cnt_ev_xfer_uf | input | 1 | Count event, code 11 (transfer counter underflow) |
| uf_pulse | output | 1 | One-cycle underflow pulse |

## Verification
A wrong enable flag becomes visible on the next control read. It also shows one strobe later as a count that moved when it should have held, or held when it should have moved. A wrong count or reload value shows up in the next count read. It also shifts the cycle in which `uf_pulse` appears, which can be seen on the clock right after the counted event. Arbitration faults show only when the colliding inputs land in the same cycle, so the bench drives those collisions together deliberately.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  localparam int CTL_W    = 8;
  localparam int EN_BIT   = 0;
  localparam int EXT_BIT  = 3;
  localparam int N_SRC    = 4;
  localparam int SRC_SELW = $clog2(N_SRC);
  localparam logic [CTL_W-1:0] CTL_WMASK = 8'hBF;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_CONT   = 1'b1
  } mode_e;

  // layout matches the register bit positions, MSB first
  typedef struct packed {
    logic                mode;
    logic                rsv;
    logic [SRC_SELW-1:0] cs;
    logic                ext;
    logic [SRC_SELW-1:0] src;
    logic                en;
  } ctl_t;
endpackage

// File: rtl/evtcnt_sel.sv
module evtcnt_sel #(
  parameter int N     = 4,
  parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     strb,
  input  logic [SEL_W-1:0] sel,
  input  logic             gate,
  output logic             hit
);
  assign hit = gate & strb[sel];
endmodule

// File: rtl/evtcnt_ctrl.sv
module evtcnt_ctrl
  import evtcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctl,
  input  logic [CTL_W-1:0] wdata,
  input  logic             arm_hit,
  input  logic             uf_evt,
  output ctl_t             ctl_q
);
  logic en_nxt;
  ctl_t ctl_d;

  // enable arbitration: software, then hardware clear, then arm
  always_comb begin
    en_nxt = ctl_q.en;
    if (wr_ctl) begin
      if (!wdata[EN_BIT])
        en_nxt = 1'b0;
      else if (!wdata[EXT_BIT])
        en_nxt = 1'b1;
    end
    if (uf_evt && (mode_e'(ctl_q.mode) == MODE_SINGLE))
      en_nxt = 1'b0;
    if (arm_hit)
      en_nxt = 1'b1;
  end

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl)
      ctl_d = ctl_t'(wdata & CTL_WMASK);
    ctl_d.en = en_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

  // R4
  sw_set_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && wdata[EXT_BIT] && !ctl_q.en && !arm_hit) |=> !ctl_q.en);
  // R5
  arm_sets_en_chk: assert property (@(posedge clk) disable iff (rst)
    arm_hit |=> ctl_q.en);
  // R9 R10
  single_uf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (uf_evt && !ctl_q.mode && !arm_hit) |=> !ctl_q.en);
endmodule

// File: rtl/evtcnt_core.sv
module evtcnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  input  logic             cnt_ev,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uf_evt,
  output logic             uf_pulse
);
  logic [CNT_W-1:0] reload_q;

  assign uf_evt = cnt_ev && !wr_cnt && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
      uf_pulse <= 1'b0;
    end else begin
      uf_pulse <= uf_evt;
      if (wr_cnt) begin
        cnt_q    <= wdata;
        reload_q <= wdata;
      end else if (cnt_ev) begin
        cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
      end
    end
  end

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_ev && !wr_cnt) |=> $stable(cnt_q));
  // R8
  uf_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_ev && !wr_cnt && cnt_q == '0) |=> (uf_pulse && cnt_q == $past(reload_q)));
endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter
  import evtcnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  input  logic             arm_ev0,
  input  logic             arm_ev1,
  input  logic             arm_nbr_uf,
  input  logic             arm_cap,
  input  logic             cnt_ev_in,
  input  logic             cnt_ev_cap,
  input  logic             cnt_ev_xfer,
  input  logic             cnt_ev_xfer_uf,
  output logic             uf_pulse
);
  ctl_t             ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             arm_hit, cnt_hit, uf_evt;
  logic             wr_ctl, wr_cnt;

  assign wr_ctl = wr_en && !wr_sel;
  assign wr_cnt = wr_en &&  wr_sel;

  evtcnt_sel #(.N(N_SRC)) u_arm_sel (
    .strb ({arm_cap, arm_nbr_uf, arm_ev1, arm_ev0}),
    .sel  (ctl_q.src),
    .gate (ctl_q.ext),
    .hit  (arm_hit)
  );

  evtcnt_sel #(.N(N_SRC)) u_cnt_sel (
    .strb ({cnt_ev_xfer_uf, cnt_ev_xfer, cnt_ev_cap, cnt_ev_in}),
    .sel  (ctl_q.cs),
    .gate (ctl_q.en),
    .hit  (cnt_hit)
  );

  evtcnt_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_ctl  (wr_ctl),
    .wdata   (wr_data[CTL_W-1:0]),
    .arm_hit (arm_hit),
    .uf_evt  (uf_evt),
    .ctl_q   (ctl_q)
  );

  evtcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .wr_cnt   (wr_cnt),
    .wdata    (wr_data),
    .cnt_ev   (cnt_hit),
    .cnt_q    (cnt_q),
    .uf_evt   (uf_evt),
    .uf_pulse (uf_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? cnt_q : CNT_W'(ctl_q);
  end

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_sel) |=> !rd_data[6]);
endmodule

// File: tb/evt_down_counter_tb.sv
module evt_down_counter_tb;
  localparam int CW = 16;
  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, wr_sel, rd_sel;
  logic [CW-1:0] wr_data;
  logic [CW-1:0] rd_data;
  logic [7:0]    strb;
  logic          uf_pulse;
  int            n_cmp = 0;
  int            n_bad = 0;

  always #4 clk = ~clk;

  evt_down_counter #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .arm_ev0(strb[0]), .arm_ev1(strb[1]), .arm_nbr_uf(strb[2]), .arm_cap(strb[3]),
    .cnt_ev_in(strb[4]), .cnt_ev_cap(strb[5]), .cnt_ev_xfer(strb[6]),
    .cnt_ev_xfer_uf(strb[7]), .uf_pulse(uf_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output int v);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    strb[idx] = 1'b1;
    @(negedge clk);
    strb = '0;
  endtask

  task automatic t_reset;
    int v;
    chk("R1 uf_pulse", int'(uf_pulse), 0);
    rd_reg(0, v); chk("R1 ctl", v, 0);
    rd_reg(1, v); chk("R1 count", v, 0);
  endtask

  task automatic t_ctl_rw;
    int v;
    wr_reg(0, 8'hFF); rd_reg(0, v); chk("R2 bit6 masked, R4 en blocked", v, 8'hBE);
    wr_reg(0, 8'h37); rd_reg(0, v); chk("R3 sw set", v, 8'h37);
    wr_reg(0, 8'h36); rd_reg(0, v); chk("R3 sw clear", v, 8'h36);
  endtask

  task automatic t_sw_block;
    int v;
    wr_reg(1, 5);
    wr_reg(0, 8'h09); rd_reg(0, v); chk("R4 ctl", v, 8'h08);
    pulse(4); rd_reg(1, v); chk("R4 count held", v, 5);
    wr_reg(0, 0);
  endtask

  task automatic t_arm;
    int v;
    for (int s = 4; s < 8; s++) begin
      wr_reg(0, s << 1);
      pulse(((s - 4) + 1) % 4); rd_reg(0, v); chk("R5 other src ignored", v & 1, 0);
      pulse(s - 4);             rd_reg(0, v); chk("R5 selected src arms", v & 1, 1);
      wr_reg(0, 0);
    end
    wr_reg(0, 8'h04);
    for (int i = 0; i < 4; i++) pulse(i);
    rd_reg(0, v); chk("R5 no ext source", v, 8'h04);
  endtask

  task automatic t_count_sel;
    int v;
    for (int k = 0; k < 4; k++) begin
      wr_reg(1, 10);
      wr_reg(0, (k << 4) | 8'h81);
      for (int e = 4; e < 8; e++) pulse(e);
      rd_reg(1, v); chk("R6 only selected counts", v, 9);
      wr_reg(0, k << 4);
      pulse(4 + k);
      rd_reg(1, v); chk("R6 disabled holds", v, 9);
    end
  endtask

  task automatic t_load;
    int v;
    wr_reg(1, 3); rd_reg(1, v); chk("R7 load", v, 3);
    wr_reg(0, 8'h81);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 7; strb[4] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; strb = '0;
    rd_reg(1, v); chk("R7 write beats event", v, 7);
  endtask

  task automatic t_underflow;
    int v;
    wr_reg(1, 2); wr_reg(0, 8'h81);
    pulse(4); pulse(4);
    chk("R8 no early pulse", int'(uf_pulse), 0);
    pulse(4); chk("R8 pulse high", int'(uf_pulse), 1);
    @(negedge clk); chk("R8 pulse one cycle", int'(uf_pulse), 0);
    rd_reg(1, v); chk("R8 reloaded", v, 2);
    rd_reg(0, v); chk("R9 continuous keeps en", v, 8'h81);
    wr_reg(1, 1); wr_reg(0, 8'h01);
    pulse(4); pulse(4); chk("R8 single pulse", int'(uf_pulse), 1);
    rd_reg(0, v); chk("R9 single clears en", v, 0);
    pulse(4); rd_reg(1, v); chk("R9 stopped after uf", v, 1);
  endtask

  task automatic t_collide;
    int v;
    wr_reg(1, 0); wr_reg(0, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h01; strb[4] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; strb = '0;
    chk("R10 uf pulse", int'(uf_pulse), 1);
    rd_reg(0, v); chk("R10 hw clear wins", v, 0);
    wr_reg(0, 8'h08); pulse(0);
    rd_reg(0, v); chk("R5 armed", v, 8'h09);
    @(negedge clk);
    strb[0] = 1'b1; strb[4] = 1'b1;
    @(negedge clk);
    strb = '0;
    rd_reg(0, v); chk("R10 arm re-sets", v, 8'h09);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; rd_sel = 1'b0;
    wr_data = '0; strb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_ctl_rw();
    t_sw_block();
    t_arm();
    t_count_sel();
    t_load();
    t_underflow();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule